// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities currently owns a shared security-device register interface. Each locality sees its own copy of an 8-bit access register, selected by the address bits that sit above the per-locality register window. Software in a locality writes that register to ask for ownership, to give it up, or to take it away from a lower-numbered owner. The block holds the single active locality, the per-locality request, seize and been-seized flags, and it forms the value read back from every access register.

An owner cannot simply be swapped while a command may be running. When a release hands the interface to a waiting locality, or when a seize is accepted, the block raises an abort request toward the command engine. The request names the locality being aborted and the one that takes over. The new ownership is applied only when the engine answers with abort-done. Every time ownership lands on a locality, the block emits a one-cycle locality-changed event that names the new owner, for use by the interrupt logic. The highest locality is reserved for a hardware-only write path, and writes to it from the ordinary bus are dropped.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality is active (`active_loc` = 7), no abort is pending, and the access register of each locality 0..4 reads 0x80 with bit 0 equal to `est_in`. Bit layout: 7 always 1, 6 always 0, 5 active, 4 been-seized, 3 seize (reads 0), 2 pending, 1 request-use, 0 establishment.
- R2: A write with bit 1 set from a locality that is not the owner, while no locality is active, makes that locality active in the same cycle.
- R3: The same write while another locality is active sets the writer's request-use flag (its bit 1). Every other locality reads bit 2 as 1 while some locality other than itself has request-use set.
- R4: The owner writing bit 5 while any locality requests raises `abort_req` with `abort_from` = owner and `abort_to` = the highest-numbered requester. `abort_req` stays high until `abort_done`. On `abort_done` that locality becomes active and has its request-use and seize flags cleared. The old owner loses active and request-use.
- R5: The owner writing bit 5 with no requesters leaves no locality active. A non-owner writing bit 5 clears only its own request-use.
- R6: A write with bit 3 set is accepted when no locality is active or the writer's number is above the owner's. It clears seize on all lower localities and raises an abort toward the writer (`abort_from` = owner, or 7 if none). On completion the old owner keeps request-use and reads bit 4 as 1.
- R7: A seize is dropped when the writer's number is not above the active owner's, when the writer already has a seize pending, or when a higher locality has a seize pending.
- R8: A write containing bit 3 ignores bits 1 and 5 of the same write.
- R9: Bit 3 always reads 0. Writing bit 4 as 1 clears the writer's been-seized flag.
- R10: Bus writes addressed to locality 4 have no effect unless `wr_hw` is high. Hardware-path writes to locality 4 behave as for any other locality.
- R11: `loc_chg` pulses for one cycle, with `loc_chg_id` = new owner, exactly when ownership moves to a locality. It stays low when ownership moves to no locality.
- R12: The locality is `addr[WIN_BITS+2:WIN_BITS]`. Only the offset `ACC_OFS` within the window reaches the access register. Other offsets, and localities 5..7, are ignored on write and read 0xFF. An `abort_done` cycle takes precedence, and a write in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_hw | input | 1 | Write comes from the hardware-only path |
| wr_addr | input | WIN_BITS+3 | Write address (locality above window offset) |
| wr_data | input | 8 | Write data for the access register |
| abort_done | input | 1 | Command engine finished the requested abort |
| est_in | input | 1 | Establishment state shown in bit 0 |
| rd_addr | input | WIN_BITS+3 | Read address |
| rd_data | output | 8 | Access register value of the addressed locality (combinational) |
| active_loc | output | 3 | Owning locality, 7 when none |
| loc_chg | output | 1 | One-cycle locality-changed event |
| loc_chg_id | output | 3 | Locality named by the last event |
| abort_req | output | 1 | Abort pending toward the command engine |
| abort_from | output | 3 | Locality whose command is aborted (7 if none) |
| abort_to | output | 3 | Locality that takes ownership on completion |

## Verification
A write or an `abort_done` is sampled on one rising edge. The ownership registers, the abort outputs and the `loc_chg` pulse all update on that same edge, so each result is due one cycle after the stimulus. `rd_data` is combinational from that state. The bench drives each stimulus on a falling edge and samples at the next falling edge, where the one-cycle event pulse is still visible. It then steps `rd_addr` across all localities within the half cycle that remains before the next rising edge.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
   localparam int   LOC_W     = 3;
   localparam int   LOC_SPACE = 1 << LOC_W;
   typedef logic [LOC_W-1:0] loc_t;
   localparam loc_t NO_LOC    = loc_t'(LOC_SPACE - 1);
   // access register bit positions
   localparam int   B_VALID   = 7;
   localparam int   B_ACT     = 5;
   localparam int   B_SEIZED  = 4;
   localparam int   B_SEIZE   = 3;
   localparam int   B_PEND    = 2;
   localparam int   B_REQ     = 1;
   localparam int   B_EST     = 0;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode import loc_arb_pkg::*; #(
   parameter int NUM_LOC  = 5,
   parameter int WIN_BITS = 12,
   parameter int ACC_OFS  = 0,
   localparam int AW      = WIN_BITS + LOC_W
)(
   input  logic [AW-1:0] addr,
   output loc_t          loc,
   output logic          hit
);
   logic ofs_ok;
   assign loc    = addr[WIN_BITS +: LOC_W];
   assign ofs_ok = (addr[WIN_BITS-1:0] == WIN_BITS'(ACC_OFS));
   assign hit    = ofs_ok && (int'(loc) < NUM_LOC);
endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick import loc_arb_pkg::*; #(
   parameter int N = LOC_SPACE
)(
   input  logic [N-1:0] vec,
   output logic         found,
   output loc_t         idx
);
   always_comb begin
      found = 1'b0;
      idx   = NO_LOC;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = loc_t'(i);
         end
      end
   end
endmodule

// File: rtl/loc_view.sv
module loc_view import loc_arb_pkg::*; #(
   parameter int NUM_LOC = 5
)(
   input  loc_t                 sel,
   input  logic                 hit,
   input  loc_t                 act,
   input  logic [LOC_SPACE-1:0] req,
   input  logic [LOC_SPACE-1:0] seized,
   input  logic                 est,
   output logic [7:0]           rd
);
   logic [7:0] view [LOC_SPACE];

   for (genvar g = 0; g < LOC_SPACE; g++) begin : g_view
      if (g < NUM_LOC) begin : g_live
         logic [LOC_SPACE-1:0] others;
         assign others = req & ~(LOC_SPACE'(1) << g);
         always_comb begin
            view[g]           = '0;
            view[g][B_VALID]  = 1'b1;
            view[g][B_ACT]    = (act == loc_t'(g));
            view[g][B_SEIZED] = seized[g];
            view[g][B_PEND]   = |others;
            view[g][B_REQ]    = req[g];
            view[g][B_EST]    = est;
         end
      end else begin : g_none
         assign view[g] = 8'hFF;
      end
   end

   assign rd = hit ? view[sel] : 8'hFF;
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter import loc_arb_pkg::*; #(
   parameter int  NUM_LOC  = 5,
   parameter int  WIN_BITS = 12,
   parameter int  ACC_OFS  = 0,
   localparam int AW       = WIN_BITS + LOC_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          wr_hw,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          abort_done,
   input  logic          est_in,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [2:0]    active_loc,
   output logic          loc_chg,
   output logic [2:0]    loc_chg_id,
   output logic          abort_req,
   output logic [2:0]    abort_from,
   output logic [2:0]    abort_to
);
   localparam loc_t HW_LOC = loc_t'(NUM_LOC - 1);

   if (NUM_LOC < 2 || NUM_LOC > LOC_SPACE - 1) begin : g_bad_num
      $error("loc_arbiter: NUM_LOC must lie in 2..%0d", LOC_SPACE - 1);
   end
   if (ACC_OFS < 0 || ACC_OFS >= (1 << WIN_BITS)) begin : g_bad_ofs
      $error("loc_arbiter: ACC_OFS outside the locality window");
   end

   // state
   loc_t                 act_q, from_q, to_q, chg_id_q;
   logic                 ab_q, chg_q;
   logic [LOC_SPACE-1:0] req_q, sz_q, seized_q;

   // next state
   loc_t                 n_act, n_from, n_to, n_chg_id;
   logic                 n_ab, n_chg;
   logic [LOC_SPACE-1:0] n_req, n_sz, n_seized;

   // decode
   loc_t wl, rl;
   logic w_hit, r_hit, wr_ok;
   loc_addr_decode #(.NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS), .ACC_OFS(ACC_OFS)) u_wdec (
      .addr(wr_addr), .loc(wl), .hit(w_hit));
   loc_addr_decode #(.NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS), .ACC_OFS(ACC_OFS)) u_rdec (
      .addr(rd_addr), .loc(rl), .hit(r_hit));
   assign wr_ok = wr_valid && w_hit && ((wl != HW_LOC) || wr_hw);

   // highest requester
   logic req_any;
   loc_t req_top;
   loc_prio_pick #(.N(LOC_SPACE)) u_pick (.vec(req_q), .found(req_any), .idx(req_top));

   // seize masks relative to the writer
   logic [LOC_SPACE-1:0] own_bit, lower_mask, higher_mask;
   assign own_bit     = LOC_SPACE'(1) << wl;
   assign lower_mask  = own_bit - LOC_SPACE'(1);
   assign higher_mask = ~(lower_mask | own_bit);

   logic [7:0] wv;
   logic       unused_wbits;
   assign unused_wbits = ^{wv[7:6], wv[B_PEND], wv[B_EST]};

   logic seize_ok;
   assign seize_ok = ((act_q == NO_LOC) || (wl > act_q)) && !sz_q[wl] && !(|(sz_q & higher_mask));

   loc_t tgt;
   logic do_set;

   always_comb begin
      n_act    = act_q;
      n_req    = req_q;
      n_sz     = sz_q;
      n_seized = seized_q;
      n_ab     = ab_q;
      n_from   = from_q;
      n_to     = to_q;
      n_chg    = 1'b0;
      n_chg_id = chg_id_q;
      tgt      = act_q;
      do_set   = 1'b0;
      wv       = wr_data;
      if (wv[B_SEIZE]) begin
         wv[B_REQ] = 1'b0;
         wv[B_ACT] = 1'b0;
      end

      if (abort_done && ab_q) begin
         do_set = 1'b1;
         tgt    = to_q;
         n_ab   = 1'b0;
      end else if (wr_ok) begin
         do_set = 1'b1;
         if (wv[B_ACT]) begin
            if (act_q == wl) begin
               if (req_any) begin
                  do_set = 1'b0;
                  n_ab   = 1'b1;
                  n_from = wl;
                  n_to   = req_top;
               end else begin
                  tgt = NO_LOC;
               end
            end else begin
               n_req[wl] = 1'b0;
            end
         end
         if (wv[B_SEIZED]) n_seized[wl] = 1'b0;
         if (wv[B_SEIZE] && seize_ok) begin
            n_sz     = (n_sz & ~lower_mask) | own_bit;
            do_set   = 1'b0;
            n_ab     = 1'b1;
            n_from   = act_q;
            n_to     = wl;
         end
         if (wv[B_REQ] && (act_q != wl)) begin
            if (act_q != NO_LOC) n_req[wl] = 1'b1;
            else                 tgt       = wl;
         end
      end

      if (do_set && (tgt != act_q)) begin
         if (act_q != NO_LOC) begin
            if ((tgt != NO_LOC) && sz_q[tgt]) n_seized[act_q] = 1'b1;
            else                              n_req[act_q]    = 1'b0;
         end
         if (tgt != NO_LOC) begin
            n_req[tgt] = 1'b0;
            n_sz[tgt]  = 1'b0;
            n_chg      = 1'b1;
            n_chg_id   = tgt;
         end
         n_act = tgt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= NO_LOC;
         req_q    <= '0;
         sz_q     <= '0;
         seized_q <= '0;
         ab_q     <= 1'b0;
         from_q   <= NO_LOC;
         to_q     <= NO_LOC;
         chg_q    <= 1'b0;
         chg_id_q <= NO_LOC;
      end else begin
         act_q    <= n_act;
         req_q    <= n_req;
         sz_q     <= n_sz;
         seized_q <= n_seized;
         ab_q     <= n_ab;
         from_q   <= n_from;
         to_q     <= n_to;
         chg_q    <= n_chg;
         chg_id_q <= n_chg_id;
      end
   end

   loc_view #(.NUM_LOC(NUM_LOC)) u_view (
      .sel(rl), .hit(r_hit), .act(act_q), .req(req_q), .seized(seized_q),
      .est(est_in), .rd(rd_data));

   assign active_loc = act_q;
   assign loc_chg    = chg_q;
   assign loc_chg_id = chg_id_q;
   assign abort_req  = ab_q;
   assign abort_from = from_q;
   assign abort_to   = to_q;
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk import loc_arb_pkg::*; #(
   parameter int  NUM_LOC  = 5,
   parameter int  WIN_BITS = 12,
   localparam int AW       = WIN_BITS + LOC_W
)(
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_hw,
   input logic [AW-1:0] wr_addr,
   input logic          abort_done,
   input logic [2:0]    active_loc,
   input logic          loc_chg,
   input logic [2:0]    loc_chg_id,
   input logic          abort_req,
   input logic [2:0]    abort_to
);
   logic [LOC_W-1:0] wloc;
   logic             unused_ofs;
   assign wloc       = wr_addr[WIN_BITS +: LOC_W];
   assign unused_ofs = ^wr_addr[WIN_BITS-1:0];

   // R1
   a_r1_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (active_loc == NO_LOC) || (int'(active_loc) < NUM_LOC));

   // R11
   a_r11_event_names_owner: assert property (@(posedge clk) disable iff (!rst_n)
      loc_chg |-> (loc_chg_id == active_loc) && (active_loc != NO_LOC));

   // R11
   a_r11_change_signalled: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(active_loc) && (active_loc != NO_LOC)) |-> loc_chg);

   // R4
   a_r4_abort_held: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && !abort_done) |=> abort_req);

   // R4
   a_r4_done_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && abort_done) |=> (active_loc == $past(abort_to)) && !abort_req);

   // R10
   a_r10_bus_hw_loc_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_hw && (int'(wloc) == NUM_LOC - 1) && !abort_req)
      |=> $stable(active_loc) && !abort_req);
endmodule

bind loc_arbiter loc_arbiter_chk #(.NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_hw(wr_hw), .wr_addr(wr_addr),
   .abort_done(abort_done), .active_loc(active_loc), .loc_chg(loc_chg),
   .loc_chg_id(loc_chg_id), .abort_req(abort_req), .abort_to(abort_to));

// File: tb/loc_arbiter_test.sv
`timescale 1ns/100ps
module loc_arbiter_test;
   localparam int WB = 12;
   localparam int AW = WB + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0, wr_hw = 1'b0, abort_done = 1'b0, est_in = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic [2:0]    active_loc, loc_chg_id, abort_from, abort_to;
   logic          loc_chg, abort_req;

   always #5 clk = ~clk;

   loc_arbiter uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_hw(wr_hw), .wr_addr(wr_addr),
      .wr_data(wr_data), .abort_done(abort_done), .est_in(est_in), .rd_addr(rd_addr),
      .rd_data(rd_data), .active_loc(active_loc), .loc_chg(loc_chg),
      .loc_chg_id(loc_chg_id), .abort_req(abort_req), .abort_from(abort_from),
      .abort_to(abort_to));

   int n_chk = 0, n_bad = 0;

   // reference state
   int         m_act = 7, m_from = 7, m_to = 7, m_evt_id = 7;
   logic [7:0] m_req = '0, m_sz = '0, m_seized = '0;
   bit         m_ab = 0, m_evt = 0;

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(int l);
      logic [7:0] o;
      if (l > 4) return 8'hFF;
      o    = 8'h80;
      o[5] = (m_act == l);
      o[4] = m_seized[l];
      o[2] = |(m_req & ~(8'd1 << l));
      o[1] = m_req[l];
      o[0] = est_in;
      return o;
   endfunction

   task automatic m_change(int t);
      if (t == m_act) return;
      if (m_act != 7) begin
         if (t != 7 && m_sz[t]) m_seized[m_act] = 1'b1;
         else                   m_req[m_act]    = 1'b0;
      end
      if (t != 7) begin
         m_req[t] = 1'b0;
         m_sz[t]  = 1'b0;
         m_evt    = 1;
         m_evt_id = t;
      end
      m_act = t;
   endtask

   task automatic m_write(int l, logic [7:0] v, bit hw);
      bit set = 1;
      int tgt = m_act;
      bit hi;
      if (l > 4 || (l == 4 && !hw)) return;
      if (v[3]) begin v[1] = 0; v[5] = 0; end
      if (v[5]) begin
         if (m_act == l) begin
            int c = -1;
            for (int k = 4; k >= 0; k--) if (c < 0 && m_req[k]) c = k;
            if (c >= 0) begin set = 0; m_ab = 1; m_from = l; m_to = c; end
            else tgt = 7;
         end else m_req[l] = 1'b0;
      end
      if (v[4]) m_seized[l] = 1'b0;
      if (v[3]) begin
         hi = 0;
         for (int k = l + 1; k < 8; k++) if (m_sz[k]) hi = 1;
         if ((m_act == 7 || l > m_act) && !m_sz[l] && !hi) begin
            for (int k = 0; k < l; k++) m_sz[k] = 1'b0;
            m_sz[l] = 1'b1;
            set = 0; m_ab = 1; m_from = m_act; m_to = l;
         end
      end
      if (v[1] && m_act != l) begin
         if (m_act != 7) m_req[l] = 1'b1;
         else            tgt = l;
      end
      if (set) m_change(tgt);
   endtask

   task automatic rd_at(int l, output logic [7:0] d);
      rd_addr = AW'(l << WB);
      #0.5;
      d = rd_data;
   endtask

   task automatic compare_all(string tag);
      logic [7:0] d;
      chk({tag, " active"}, 32'(active_loc), 32'(m_act));
      chk({tag, " R11 event"}, 32'(loc_chg), 32'(m_evt));
      if (m_evt) chk({tag, " R11 event id"}, 32'(loc_chg_id), 32'(m_evt_id));
      chk({tag, " R4 abort_req"}, 32'(abort_req), 32'(m_ab));
      if (m_ab) begin
         chk({tag, " R6 abort_from"}, 32'(abort_from), 32'(m_from));
         chk({tag, " R4 abort_to"}, 32'(abort_to), 32'(m_to));
      end
      for (int l = 0; l < 5; l++) begin
         rd_at(l, d);
         chk($sformatf("%s R9 read L%0d", tag, l), 32'(d), 32'(exp_rd(l)));
      end
   endtask

   task automatic op_write(string tag, int l, logic [7:0] v, bit hw, int ofs = 0);
      @(negedge clk);
      wr_valid = 1; wr_hw = hw; wr_data = v;
      wr_addr  = AW'((l << WB) | ofs);
      m_evt    = 0;
      if (ofs == 0) m_write(l, v, hw);
      @(negedge clk);
      wr_valid = 0; wr_hw = 0;
      compare_all(tag);
   endtask

   task automatic op_done(string tag);
      @(negedge clk);
      abort_done = 1;
      m_evt = 0;
      if (m_ab) begin m_change(m_to); m_ab = 0; end
      @(negedge clk);
      abort_done = 0;
      compare_all(tag);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h1A2B));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      compare_all("R1 reset");
      rd_at(2, d);
      chk("R1 reset value", 32'(d), 32'h80);

      op_write("R2 grab", 1, 8'h02, 0);
      chk("R2 owner is 1", 32'(active_loc), 32'd1);
      op_write("R3 req3", 3, 8'h02, 0);
      rd_at(3, d); chk("R3 requester flag", 32'(d), 32'h82);
      rd_at(1, d); chk("R3 pending seen by owner", 32'(d), 32'hA4);
      op_write("R3 req2", 2, 8'h02, 0);
      op_write("R4 release", 1, 8'h20, 0);
      chk("R4 abort to highest", 32'(abort_to), 32'd3);
      op_done("R4 done");
      chk("R4 new owner", 32'(active_loc), 32'd3);
      op_write("R5 nonowner release", 2, 8'h20, 0);
      rd_at(2, d); chk("R5 own request cleared", 32'(d), 32'h80);
      op_write("R5 release none", 3, 8'h20, 0);
      chk("R5 nobody active", 32'(active_loc), 32'd7);
      chk("R11 no event on none", 32'(loc_chg), 32'd0);

      op_write("R2 grab0", 0, 8'h02, 0);
      op_write("R3 req2b", 2, 8'h02, 0);
      op_write("R6 seize1", 1, 8'h08, 0);
      chk("R6 abort from 0", 32'(abort_from), 32'd0);
      rd_at(1, d); chk("R9 seize bit reads 0", 32'(d), 32'h84);
      op_done("R6 done");
      rd_at(0, d); chk("R6 been-seized on old owner", 32'(d), 32'h94);
      op_write("R9 clear seized", 0, 8'h10, 0);
      rd_at(0, d); chk("R9 been-seized cleared", 32'(d), 32'h84);
      op_write("R7 low seize", 0, 8'h08, 0);
      chk("R7 low seize ignored", 32'(abort_req), 32'd0);
      op_write("R8 seize+req", 3, 8'h2A, 0);
      rd_at(3, d); chk("R8 request bit discarded", 32'(d), 32'h84);
      op_write("R7 under higher seize", 2, 8'h08, 0);
      chk("R7 target kept", 32'(abort_to), 32'd3);
      op_done("R8 done");
      op_write("R10 bus to L4", 4, 8'h08, 0);
      chk("R10 bus write dropped", 32'(abort_req), 32'd0);
      op_write("R10 hw to L4", 4, 8'h08, 1);
      chk("R10 hw seize accepted", 32'(abort_to), 32'd4);
      op_done("R10 done");
      chk("R10 hw owner", 32'(active_loc), 32'd4);

      rd_at(5, d); chk("R12 locality 5 reads FF", 32'(d), 32'hFF);
      op_write("R12 other offset", 1, 8'h02, 0, 4);
      rd_at(1, d); chk("R12 offset write ignored", 32'(d), 32'h94);
      est_in = 1;
      rd_at(2, d); chk("R1 establishment bit", 32'(d[0]), 32'd1);
      est_in = 0;

      for (int i = 0; i < 400; i++) begin
         if (m_ab && ($urandom % 2)) op_done("R4 random done");
         else begin
            logic [7:0] v;
            case ($urandom % 7)
               0: v = 8'h02;
               1: v = 8'h20;
               2: v = 8'h08;
               3: v = 8'h10;
               4: v = 8'h0A;
               5: v = 8'h22;
               default: v = 8'($urandom);
            endcase
            op_write("R6 random", int'($urandom % 5), v, bit'($urandom % 2));
         end
      end

      summary();
      $finish;
   end
endmodule